// File: doc/BRIEF.md
# Vectored Interrupt Controller with Alias Enable Registers

This block collects up to 32 interrupt request lines, holds each one in a status bit, and masks it with a per-source enable. A processor reaches it through a small word-addressed register file on a 32-bit bus. It raises a single interrupt line when any unmasked request is held and the controller is switched on. Reading the vector register tells the handler which source to service first. The handler then writes that source's bit to the acknowledge register to retire it.

Software can change a single enable bit atomically, without a read-modify-write. One alias register turns on the enable bits it is given, and another turns them off. The build-time parameter `EDGE_MASK` fixes each input as edge or level sensitive. An edge input is caught on its rising transition and held until acknowledged. A level input is caught whenever it is high, so acknowledging it has no lasting effect while the line stays active.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, status, pending, enable and master enable all read zero, the vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: An edge source (its `EDGE_MASK` bit is 1) sets its status bit, read at byte offset 0 with bit n for source n, on the clock after its input goes from low to high. The bit stays set after the input falls, until it is acknowledged.
- R3: A level source (its `EDGE_MASK` bit is 0) sets its status bit on every clock where its input is high. An acknowledge while the input is still high leaves the bit set. An acknowledge after the input has dropped clears it.
- R4: A write to offset 12 clears the status bit of every source whose data bit is 1 and leaves all other status bits alone. A write of 0xFFFFFFFF clears every held edge request.
- R5: An edge source whose rising edge arrives on the same clock as an acknowledge of its own bit keeps its status bit set.
- R6: A write to offset 8 replaces the whole enable register. A write to offset 16 sets the enable bits given as 1. A write to offset 20 clears the enable bits given as 1. Neither alias write changes any other enable bit.
- R7: Offset 4 reads pending, which is the bitwise AND of status and enable.
- R8: Offset 28 holds a two-bit master enable: writes keep data bits 1:0, and reads return them with all upper bits zero. `irq_out` is high exactly when pending is nonzero and master enable bit 0 is 1.
- R9: Offset 24 reads the number of the lowest-numbered pending source, or 0xFFFFFFFF when nothing is pending.
- R10: Reads of offsets 12, 16 and 20 return zero, and writes to offsets 0, 4 and 24 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one transfer per clock |
| reg_addr | input | 5 | Byte address of the register, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_src | input | 32 | Interrupt request inputs, active high |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the request inputs are synchronous to `clk` and that every level request is held low while reset is asserted. They also assume that a write occupies exactly one clock with a stable address. The stimulus changes inputs only on falling clock edges and keeps `irq_src` at zero throughout reset. Random writes are confined to the eight aligned offsets, so every transfer lands on a defined register. Within that space the random data freely mixes acknowledges with new edges, toggles master enable, and issues alias writes on any clock.

// File: rtl/vic_pkg.sv
package vic_pkg;
   // register slot = reg_addr[4:2]; order is the bus map
   typedef enum logic [2:0] {
      SLOT_STATUS = 3'd0,
      SLOT_PEND   = 3'd1,
      SLOT_ENA    = 3'd2,
      SLOT_ACK    = 3'd3,
      SLOT_SETENA = 3'd4,
      SLOT_CLRENA = 3'd5,
      SLOT_VEC    = 3'd6,
      SLOT_MASTER = 3'd7
   } vic_slot_e;

   localparam int MASTER_W = 2;
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell #(
   parameter bit IS_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_in,
   input  logic ack,
   output logic held
);
   generate
      if (IS_EDGE) begin : g_edge
         logic req_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               req_d <= 1'b0;
               held  <= 1'b0;
            end else begin
               req_d <= req_in;
               // a new edge wins over a coincident acknowledge
               held  <= (held & ~ack) | (req_in & ~req_d);
            end
         end
      end else begin : g_level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held <= 1'b0;
            else        held <= (held & ~ack) | req_in;
         end
      end
   endgenerate
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
   parameter int N     = 32,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int          NUM_SRC   = 32,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 5,
   parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_SRC-1:0] irq_src,
   output logic              irq_out
);
   localparam int IDX_W = $clog2(NUM_SRC);

   generate
      if (NUM_SRC < 2 || NUM_SRC > DATA_W || NUM_SRC > 32) begin : g_bad_nsrc
         $error("vec_irq_ctrl: NUM_SRC out of range");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("vec_irq_ctrl: ADDR_W too small for eight word registers");
      end
      if (DATA_W < MASTER_W) begin : g_bad_data
         $error("vec_irq_ctrl: DATA_W too small");
      end
   endgenerate

   vic_slot_e            slot;
   logic                 aligned;
   logic                 wr_hit;
   logic [NUM_SRC-1:0]   wmask;
   logic [NUM_SRC-1:0]   ack_mask;
   logic [NUM_SRC-1:0]   status_q;
   logic [NUM_SRC-1:0]   enable_q;
   logic [NUM_SRC-1:0]   pending;
   logic [MASTER_W-1:0]  master_q;
   logic                 win_any;
   logic [IDX_W-1:0]     win_idx;

   assign slot     = vic_slot_e'(reg_addr[4:2]);
   assign aligned  = (reg_addr[1:0] == 2'b00) && (ADDR_W == 5 || reg_addr[ADDR_W-1:5] == '0);
   assign wr_hit   = reg_we && aligned;
   assign wmask    = reg_wdata[NUM_SRC-1:0];
   assign ack_mask = (wr_hit && slot == SLOT_ACK) ? wmask : '0;

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      vic_src_cell #(.IS_EDGE(EDGE_MASK[n])) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .req_in (irq_src[n]),
         .ack    (ack_mask[n]),
         .held   (status_q[n])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         master_q <= '0;
      end else if (wr_hit) begin
         unique case (slot)
            SLOT_ENA:    enable_q <= wmask;
            SLOT_SETENA: enable_q <= enable_q | wmask;
            SLOT_CLRENA: enable_q <= enable_q & ~wmask;
            SLOT_MASTER: master_q <= reg_wdata[MASTER_W-1:0];
            default:     ;
         endcase
      end
   end

   assign pending = status_q & enable_q;

   vic_prio_enc #(.N(NUM_SRC)) u_prio (
      .req   (pending),
      .found (win_any),
      .idx   (win_idx)
   );

   assign irq_out = win_any & master_q[0];

   always_comb begin
      reg_rdata = '0;
      if (aligned) begin
         unique case (slot)
            SLOT_STATUS: reg_rdata = DATA_W'(status_q);
            SLOT_PEND:   reg_rdata = DATA_W'(pending);
            SLOT_ENA:    reg_rdata = DATA_W'(enable_q);
            SLOT_VEC:    reg_rdata = win_any ? DATA_W'(win_idx) : '1;
            SLOT_MASTER: reg_rdata = DATA_W'(master_q);
            default:     reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
   parameter int          NUM_SRC   = 32,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 5,
   parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF,
   localparam int IDX_W = $clog2(NUM_SRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic [NUM_SRC-1:0] irq_src,
   input logic               irq_out,
   input logic [NUM_SRC-1:0] status_q,
   input logic [NUM_SRC-1:0] enable_q,
   input logic [NUM_SRC-1:0] ack_mask,
   input logic [1:0]         master_q,
   input logic               win_any,
   input logic [IDX_W-1:0]   win_idx
);
   localparam logic [NUM_SRC-1:0] LVL = ~EDGE_MASK[NUM_SRC-1:0];
   localparam logic [ADDR_W-1:0]  CLR_ADDR = ADDR_W'(20);

   logic [NUM_SRC-1:0] pend;
   assign pend = status_q & enable_q;

   // R2: without an acknowledge no held bit ever drops
   p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ack_mask) == '0) |-> ((status_q & $past(status_q)) == $past(status_q)));

   // R3: a level line high on one clock is held on the next
   p_level_relatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((($past(irq_src) & LVL) & ~status_q) == '0));

   // R6: a clear-enable write leaves its bits off
   p_clear_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_we && reg_addr == CLR_ADDR) |->
         ((enable_q & $past(reg_wdata[NUM_SRC-1:0])) == '0));

   // R8: output stays low with nothing pending or master off
   p_no_irq_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0 || !master_q[0]) |-> !irq_out);

   // R9: the winner is pending and nothing below it is
   p_vector_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      win_any |-> (pend[win_idx] &&
         ((pend & ((NUM_SRC'(1) << win_idx) - NUM_SRC'(1))) == '0)));

   p_vector_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !win_any |-> (pend == '0));
endmodule

bind vec_irq_ctrl vic_checker #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EDGE_MASK(EDGE_MASK)
) u_vic_checker (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .irq_src(irq_src), .irq_out(irq_out),
   .status_q(status_q), .enable_q(enable_q), .ack_mask(ack_mask),
   .master_q(master_q), .win_any(win_any), .win_idx(win_idx)
);

// File: tb/tb_vec_irq_ctrl.sv
`timescale 1ns/100ps
module tb_vec_irq_ctrl;
   localparam logic [31:0] EDGES = 32'h0000_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] irq_src = '0;
   logic        irq_out;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 0;

   logic [31:0] m_stat = '0, m_ena = '0, m_srcq = '0;
   logic [1:0]  m_mst = '0;

   vec_irq_ctrl #(.EDGE_MASK(EDGES)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_src(irq_src),
      .irq_out(irq_out)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [31:0] exp_vec(logic [31:0] p);
      for (int i = 31; i >= 0; i--) if (p[i]) exp_vec = 32'(i);
      if (p == '0) exp_vec = 32'hFFFF_FFFF;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.4;
      d = reg_rdata;
   endtask

   // one clock with the given inputs; reference model follows the requirements
   task automatic tick(logic we, logic [4:0] a, logic [31:0] wd, logic [31:0] src);
      logic [31:0] ackm;
      @(negedge clk);
      reg_we = we; reg_addr = a; reg_wdata = wd; irq_src = src;
      @(posedge clk);
      ackm = (we && a == 5'd12) ? wd : '0;
      m_stat = (m_stat & ~ackm) | (src & ~m_srcq & EDGES) | (src & ~EDGES);
      if (we) begin
         case (a)
            5'd8:  m_ena = wd;
            5'd16: m_ena = m_ena | wd;
            5'd20: m_ena = m_ena & ~wd;
            5'd28: m_mst = wd[1:0];
            default: ;
         endcase
      end
      m_srcq = src;
      #0.5;
      reg_we = 1'b0;
   endtask

   task automatic check_all(string req);
      logic [31:0] d;
      rd(5'd0, d);  chk({req, " status"}, d, m_stat);
      rd(5'd4, d);  chk({req, " pending"}, d, m_stat & m_ena);
      rd(5'd8, d);  chk({req, " enable"}, d, m_ena);
      rd(5'd24, d); chk({req, " vector"}, d, exp_vec(m_stat & m_ena));
      rd(5'd28, d); chk({req, " master"}, d, {30'd0, m_mst});
      chk({req, " irq_out"}, {31'd0, irq_out}, {31'd0, (|(m_stat & m_ena)) & m_mst[0]});
   endtask

   initial begin
      logic [31:0] d;
      logic [4:0]  offs [8] = '{5'd0, 5'd4, 5'd8, 5'd12, 5'd16, 5'd20, 5'd24, 5'd28};
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #0.5;
      check_all("R1");

      // R2: edge source 3 latches, holds after drop
      tick(1, 5'd8, 32'hFFFF_FFFF, 32'h0000_0008);
      tick(1, 5'd28, 32'h3, 32'h0);
      rd(5'd0, d); chk("R2 edge latched", d, 32'h0000_0008);
      tick(0, 5'd0, 0, 32'h0);
      rd(5'd0, d); chk("R2 edge held after drop", d, 32'h0000_0008);
      check_all("R2");

      // R9: lowest pending wins
      tick(0, 5'd0, 0, 32'h0000_0021);
      rd(5'd24, d); chk("R9 lowest source", d, 32'd0);
      // R4: ack only bit 0
      tick(1, 5'd12, 32'h1, 32'h0);
      rd(5'd0, d); chk("R4 ack one bit", d, 32'h0000_0028);
      rd(5'd24, d); chk("R9 next source", d, 32'd3);

      // R3: level source 20
      tick(0, 5'd0, 0, 32'h0010_0000);
      tick(1, 5'd12, 32'h0010_0000, 32'h0010_0000);
      rd(5'd0, d); chk("R3 level relatched", d[20] ? 32'd1 : 32'd0, 32'd1);
      tick(0, 5'd0, 0, 32'h0);
      tick(1, 5'd12, 32'h0010_0000, 32'h0);
      rd(5'd0, d); chk("R3 level cleared", d[20] ? 32'd1 : 32'd0, 32'd0);

      // R4: all ones clears everything
      tick(1, 5'd12, 32'hFFFF_FFFF, 32'h0);
      rd(5'd0, d); chk("R4 ack all", d, 32'h0);
      rd(5'd24, d); chk("R9 none pending", d, 32'hFFFF_FFFF);
      chk("R8 idle low", {31'd0, irq_out}, 32'd0);

      // R5: ack coincident with a new edge on the same source
      tick(0, 5'd0, 0, 32'h0000_0002);
      tick(0, 5'd0, 0, 32'h0);
      tick(1, 5'd12, 32'h2, 32'h0000_0002);
      rd(5'd0, d); chk("R5 edge beats ack", d, 32'h0000_0002);
      check_all("R5");

      // R6: enable replace and aliases
      tick(1, 5'd8, 32'h0000_00F0, 32'h0);
      tick(1, 5'd16, 32'h0000_0003, 32'h0);
      rd(5'd8, d); chk("R6 set alias", d, 32'h0000_00F3);
      tick(1, 5'd20, 32'h0000_0030, 32'h0);
      rd(5'd8, d); chk("R6 clear alias", d, 32'h0000_00C3);
      // R7 pending masked by enable
      rd(5'd4, d); chk("R7 pending", d, 32'h0000_0002);

      // R8: master enable gating and width
      tick(1, 5'd28, 32'h2, 32'h0);
      chk("R8 bit0 off", {31'd0, irq_out}, 32'd0);
      tick(1, 5'd28, 32'hFFFF_FFFF, 32'h0);
      rd(5'd28, d); chk("R8 two bits", d, 32'h3);
      chk("R8 on", {31'd0, irq_out}, 32'd1);
      tick(1, 5'd20, 32'hFFFF_FFFF, 32'h0);
      chk("R8 all disabled", {31'd0, irq_out}, 32'd0);

      // R10: alias reads zero, read-only writes ignored
      rd(5'd12, d); chk("R10 ack reads 0", d, 32'h0);
      rd(5'd16, d); chk("R10 set reads 0", d, 32'h0);
      rd(5'd20, d); chk("R10 clr reads 0", d, 32'h0);
      tick(1, 5'd0, 32'hFFFF_FFFF, 32'h0);
      tick(1, 5'd4, 32'hFFFF_FFFF, 32'h0);
      tick(1, 5'd24, 32'hFFFF_FFFF, 32'h0);
      check_all("R10");

      // random mix, all requirements against the model
      for (int k = 0; k < 400; k++) begin
         logic [31:0] src;
         src = $urandom();
         if (($urandom() & 3) != 0) src = src & m_srcq | ($urandom() & $urandom());
         tick(($urandom() & 1) == 1, offs[$urandom() % 8], $urandom(), src);
         check_all("R2/R3/R4/R5/R6/R7/R8/R9 random");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule